// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Merger

This combinational unit sits between the address stage and the register file of a 32-bit core that reads and writes a big-endian, word-addressed memory. It receives the 6-bit transfer opcode, the low two bits of the effective byte address, the current contents of the rt register, and the aligned memory word (always fetched with the two low address bits cleared, for stores as well as loads). For a load it forms the value to write back to rt. For a store it forms the complete word to write back to memory, merging the new bytes into the fetched word.

Byte lanes are numbered in big-endian order: address offset 0 selects bits 31:24 and offset 3 selects bits 7:0. Partial stores are therefore read-modify-write merges, and the unaligned left/right transfers merge across the lane boundary with shift-derived masks. Load-linked acts as a plain word load. Store-conditional stores rt and also returns the value 1 for rt. Reservation tracking, the memory and the register file are outside this block. Any opcode outside the supported set raises an error flag and suppresses both writes.

Top module: `lsm_lane_merge`

## Requirements
- R1: Opcode 0x20 returns the byte at lane `lane` (lane 0 = bits 31:24) sign-extended from its bit 7; opcode 0x24 returns the same byte zero-extended.
- R2: Opcode 0x21 returns the halfword made of lanes `lane & 2` and `(lane & 2)+1` (lower-numbered lane in the upper bits), sign-extended from bit 15; opcode 0x25 zero-extends it.
- R3: Opcodes 0x23 (word load) and 0x30 (load-linked) return the memory word unchanged with `reg_we` = 1 and `mem_we` = 0.
- R4: Opcode 0x22 (load-left) returns, for each result lane i with i + lane <= 3, memory lane i + lane, and rt lane i for every other lane.
- R5: Opcode 0x26 (load-right) returns, for each result lane i with i >= 3 - lane, memory lane i - (3 - lane), and rt lane i for every other lane.
- R6: Opcode 0x28 replaces memory lane `lane` with rt bits 7:0; opcode 0x29 replaces lanes `lane & 2` and `(lane & 2)+1` with rt bits 15:8 and 7:0. Every other lane of the memory word is kept.
- R7: Opcode 0x2A (store-left) writes rt lane i - lane into word lane i for i >= lane; opcode 0x2E (store-right) writes rt lane i + 3 - lane into word lane i for i <= lane; all other lanes keep the memory word.
- R8: Opcodes 0x2B (word store) and 0x38 (store-conditional) put rt unchanged on `wdata` with `mem_we` = 1.
- R9: For opcode 0x38 `result` is 1 and `reg_we` equals 1 exactly when `rt_idx` is not 0.
- R10: `mem_we` is 1 exactly for the store opcodes 0x28, 0x29, 0x2A, 0x2B, 0x2E and 0x38; `reg_we` is 1 for all loads (0x20 to 0x26 and 0x30) and 0 for stores other than 0x38. On a load `wdata` is 0; on a store other than 0x38 `result` is 0.
- R11: Any other opcode sets `bad_op` = 1 with `result` = 0, `wdata` = 0, `mem_we` = 0 and `reg_we` = 0; `bad_op` is 0 for every supported opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 6 | Transfer opcode |
| lane | input | 2 | Low two bits of the effective byte address |
| rt_val | input | 32 | Current value of the rt register |
| rt_idx | input | 5 | Index of the rt register |
| mem_word | input | 32 | Memory word read at the aligned address |
| result | output | 32 | Value for the rt register |
| reg_we | output | 1 | Register write enable |
| wdata | output | 32 | Merged word to store at the aligned address |
| mem_we | output | 1 | Memory write enable |
| bad_op | output | 1 | Unsupported opcode |

## Verification
The hardest cases to reach are the unaligned left/right merges at the middle offsets. There, rt lanes and memory lanes meet in the same output word, and an off-by-one-lane error in the shift or the mask only shows if every lane holds a distinct byte. The stimulus therefore runs a directed sweep of all four offsets for all four unaligned opcodes, using words whose bytes all differ from each other and from rt. It then runs a long seeded random mix, weighted toward the supported opcodes, with occasional arbitrary opcodes and an rt index of zero to exercise the error path and the store-conditional link gating.

// File: rtl/lsm_pkg.sv
// Package: shared opcode values and transfer kinds for the lane merger.
// Assumes 6-bit opcodes; only the listed values are supported.
package lsm_pkg;

    localparam logic [5:0] OPC_LDB_S  = 6'h20;
    localparam logic [5:0] OPC_LDH_S  = 6'h21;
    localparam logic [5:0] OPC_LDLEFT = 6'h22;
    localparam logic [5:0] OPC_LDW    = 6'h23;
    localparam logic [5:0] OPC_LDB_U  = 6'h24;
    localparam logic [5:0] OPC_LDH_U  = 6'h25;
    localparam logic [5:0] OPC_LDRGHT = 6'h26;
    localparam logic [5:0] OPC_STB    = 6'h28;
    localparam logic [5:0] OPC_STH    = 6'h29;
    localparam logic [5:0] OPC_STLEFT = 6'h2A;
    localparam logic [5:0] OPC_STW    = 6'h2B;
    localparam logic [5:0] OPC_STRGHT = 6'h2E;
    localparam logic [5:0] OPC_LDLINK = 6'h30;
    localparam logic [5:0] OPC_STCOND = 6'h38;

    typedef enum logic [3:0] {
        XK_NONE,
        XK_LB_S,
        XK_LB_U,
        XK_LH_S,
        XK_LH_U,
        XK_LWORD,
        XK_LLEFT,
        XK_LRIGHT,
        XK_SBYTE,
        XK_SHALF,
        XK_SWORD,
        XK_SLEFT,
        XK_SRIGHT
    } xfer_kind_e;

endpackage

// File: rtl/lsm_decode.sv
// Module: lsm_decode
// Classifies an opcode into a transfer kind plus load/store/conditional/error
// flags. Assumes the opcode is already the primary 6-bit field.
module lsm_decode
    import lsm_pkg::*;
(
    input  logic [5:0]  op,
    output xfer_kind_e  kind,
    output logic        is_load,
    output logic        is_store,
    output logic        is_cond,
    output logic        is_bad
);

    // Purpose: map each supported opcode to its kind and class flags.
    always_comb begin
        kind     = XK_NONE;
        is_load  = 1'b0;
        is_store = 1'b0;
        is_cond  = 1'b0;
        is_bad   = 1'b0;
        case (op)
            OPC_LDB_S:  begin kind = XK_LB_S;   is_load = 1'b1; end
            OPC_LDB_U:  begin kind = XK_LB_U;   is_load = 1'b1; end
            OPC_LDH_S:  begin kind = XK_LH_S;   is_load = 1'b1; end
            OPC_LDH_U:  begin kind = XK_LH_U;   is_load = 1'b1; end
            OPC_LDW:    begin kind = XK_LWORD;  is_load = 1'b1; end
            OPC_LDLINK: begin kind = XK_LWORD;  is_load = 1'b1; end
            OPC_LDLEFT: begin kind = XK_LLEFT;  is_load = 1'b1; end
            OPC_LDRGHT: begin kind = XK_LRIGHT; is_load = 1'b1; end
            OPC_STB:    begin kind = XK_SBYTE;  is_store = 1'b1; end
            OPC_STH:    begin kind = XK_SHALF;  is_store = 1'b1; end
            OPC_STW:    begin kind = XK_SWORD;  is_store = 1'b1; end
            OPC_STCOND: begin kind = XK_SWORD;  is_store = 1'b1; is_cond = 1'b1; end
            OPC_STLEFT: begin kind = XK_SLEFT;  is_store = 1'b1; end
            OPC_STRGHT: begin kind = XK_SRIGHT; is_store = 1'b1; end
            default:    begin is_bad = 1'b1; end
        endcase
    end

    // Purpose: every opcode lands in exactly one class.
    always_comb begin
        p_one_class_r11: assert ($countones({is_load, is_store, is_bad}) == 1)
            else $error("opcode fell into zero or several classes");
        p_cond_is_store_r9: assert (!is_cond || is_store)
            else $error("conditional flag without store");
    end

endmodule

// File: rtl/lsm_lane_shift.sv
// Module: lsm_lane_shift
// Derives the bit shift amounts used by both paths from the lane offset.
// Assumes WORD_W is a power-of-two multiple of BYTE_W of at least two lanes.
module lsm_lane_shift #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES  = WORD_W / BYTE_W,
    localparam int LANE_W = $clog2(LANES),
    localparam int SH_W   = $clog2(WORD_W)
) (
    input  logic [LANE_W-1:0] lane,
    output logic [SH_W-1:0]   sh_fwd,
    output logic [SH_W-1:0]   sh_rev,
    output logic [SH_W-1:0]   sh_half
);

    localparam logic [SH_W-1:0] TOP_BYTE = SH_W'(WORD_W - BYTE_W);
    localparam logic [SH_W-1:0] TOP_HALF = SH_W'(WORD_W - 2 * BYTE_W);
    localparam logic [SH_W-1:0] BYTE_SH  = SH_W'(BYTE_W);

    logic [LANE_W-1:0] lane_even;

    // Purpose: lane rounded down to an even (halfword) boundary.
    always_comb begin
        lane_even    = lane;
        lane_even[0] = 1'b0;
    end

    // Purpose: forward, reversed and halfword shift amounts in bits.
    always_comb begin
        sh_fwd  = SH_W'(lane) * BYTE_SH;
        sh_rev  = TOP_BYTE - sh_fwd;
        sh_half = TOP_HALF - SH_W'(lane_even) * BYTE_SH;
    end

    // Purpose: forward and reversed shifts always add to the top-byte offset.
    always_comb begin
        p_shift_sum_r1: assert (SH_W'(sh_fwd + sh_rev) == TOP_BYTE)
            else $error("lane shift pair inconsistent");
    end

endmodule

// File: rtl/lsm_load_path.sv
// Module: lsm_load_path
// Forms the register value for every load kind, merging with rt for the
// unaligned left/right forms. Assumes mem_word is the aligned word.
module lsm_load_path
    import lsm_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES  = WORD_W / BYTE_W,
    localparam int LANE_W = $clog2(LANES),
    localparam int SH_W   = $clog2(WORD_W),
    localparam int HALF_W = 2 * BYTE_W
) (
    input  xfer_kind_e        kind,
    input  logic [LANE_W-1:0] lane,
    input  logic [SH_W-1:0]   sh_fwd,
    input  logic [SH_W-1:0]   sh_rev,
    input  logic [SH_W-1:0]   sh_half,
    input  logic [WORD_W-1:0] rt_val,
    input  logic [WORD_W-1:0] mem_word,
    output logic [WORD_W-1:0] ld_val
);

    localparam logic [WORD_W-1:0] ALL_ONES = '1;

    logic [BYTE_W-1:0] byte_f;
    logic [HALF_W-1:0] half_f;
    logic [WORD_W-1:0] left_keep;
    logic [WORD_W-1:0] right_keep;

    // Purpose: extract the addressed byte and halfword fields.
    always_comb begin
        byte_f = BYTE_W'(mem_word >> sh_rev);
        half_f = HALF_W'(mem_word >> sh_half);
    end

    // Purpose: masks of rt bits that survive an unaligned load.
    always_comb begin
        left_keep  = ~(ALL_ONES << sh_fwd);
        right_keep = ~(ALL_ONES >> sh_rev);
    end

    // Purpose: select the load result by kind.
    always_comb begin
        case (kind)
            XK_LB_S:   ld_val = {{(WORD_W - BYTE_W){byte_f[BYTE_W-1]}}, byte_f};
            XK_LB_U:   ld_val = WORD_W'(byte_f);
            XK_LH_S:   ld_val = {{(WORD_W - HALF_W){half_f[HALF_W-1]}}, half_f};
            XK_LH_U:   ld_val = WORD_W'(half_f);
            XK_LWORD:  ld_val = mem_word;
            XK_LLEFT:  ld_val = (rt_val & left_keep) | (mem_word << sh_fwd);
            XK_LRIGHT: ld_val = (rt_val & right_keep) | (mem_word >> sh_rev);
            default:   ld_val = '0;
        endcase
    end

    // Purpose: guard sign extension and the fully aligned unaligned cases.
    always_comb begin
        p_byte_sext_r1: assert (kind != XK_LB_S ||
                                ld_val[WORD_W-1:BYTE_W] == {(WORD_W - BYTE_W){ld_val[BYTE_W-1]}})
            else $error("signed byte load not sign-extended");
        p_half_zext_r2: assert (kind != XK_LH_U || ld_val[WORD_W-1:HALF_W] == '0)
            else $error("unsigned halfword load has upper bits set");
        p_left_aligned_r4: assert (kind != XK_LLEFT || lane != '0 || ld_val == mem_word)
            else $error("aligned load-left differs from memory word");
        p_right_aligned_r5: assert (kind != XK_LRIGHT || lane != LANE_W'(LANES - 1) ||
                                    ld_val == mem_word)
            else $error("aligned load-right differs from memory word");
    end

endmodule

// File: rtl/lsm_store_path.sv
// Module: lsm_store_path
// Forms the word written back to memory for every store kind by merging rt
// bytes into the fetched aligned word. Assumes mem_word is that word.
module lsm_store_path
    import lsm_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES  = WORD_W / BYTE_W,
    localparam int SH_W   = $clog2(WORD_W),
    localparam int HALF_W = 2 * BYTE_W
) (
    input  xfer_kind_e        kind,
    input  logic [SH_W-1:0]   sh_fwd,
    input  logic [SH_W-1:0]   sh_rev,
    input  logic [SH_W-1:0]   sh_half,
    input  logic [WORD_W-1:0] rt_val,
    input  logic [WORD_W-1:0] mem_word,
    output logic [WORD_W-1:0] st_val
);

    localparam logic [WORD_W-1:0] ALL_ONES  = '1;
    localparam logic [WORD_W-1:0] BYTE_ONES = WORD_W'({BYTE_W{1'b1}});
    localparam logic [WORD_W-1:0] HALF_ONES = WORD_W'({HALF_W{1'b1}});

    logic [WORD_W-1:0] byte_mask;
    logic [WORD_W-1:0] half_mask;
    logic [LANES-1:0]  lane_diff;

    // Purpose: positions of the lanes overwritten by byte and halfword stores.
    always_comb begin
        byte_mask = BYTE_ONES << sh_rev;
        half_mask = HALF_ONES << sh_half;
    end

    // Purpose: select the merged store word by kind.
    always_comb begin
        case (kind)
            XK_SBYTE:  st_val = (mem_word & ~byte_mask) |
                                (WORD_W'(rt_val[BYTE_W-1:0]) << sh_rev);
            XK_SHALF:  st_val = (mem_word & ~half_mask) |
                                (WORD_W'(rt_val[HALF_W-1:0]) << sh_half);
            XK_SWORD:  st_val = rt_val;
            XK_SLEFT:  st_val = (mem_word & ~(ALL_ONES >> sh_fwd)) | (rt_val >> sh_fwd);
            XK_SRIGHT: st_val = (mem_word & ~(ALL_ONES << sh_rev)) | (rt_val << sh_rev);
            default:   st_val = '0;
        endcase
    end

    // Purpose: per-lane change flags between fetched and merged words.
    for (genvar g = 0; g < LANES; g++) begin : g_lane_diff
        assign lane_diff[g] = |(st_val[g*BYTE_W +: BYTE_W] ^ mem_word[g*BYTE_W +: BYTE_W]);
    end

    // Purpose: partial stores touch at most their own lanes.
    always_comb begin
        p_byte_one_lane_r6: assert (kind != XK_SBYTE || $onehot0(lane_diff))
            else $error("byte store changed more than one lane");
        p_half_two_lanes_r6: assert (kind != XK_SHALF || $countones(lane_diff) <= 2)
            else $error("halfword store changed more than two lanes");
    end

endmodule

// File: rtl/lsm_lane_merge.sv
// Module: lsm_lane_merge (top)
// Combinational big-endian load/store lane merger: register result for loads,
// merged memory word for stores, enables and an error flag.
// Assumes mem_word was fetched at the address with its low bits cleared.
module lsm_lane_merge
    import lsm_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    parameter int REG_IDX_W = 5,
    localparam int LANES  = WORD_W / BYTE_W,
    localparam int LANE_W = $clog2(LANES),
    localparam int SH_W   = $clog2(WORD_W)
) (
    input  logic [5:0]           op,
    input  logic [LANE_W-1:0]    lane,
    input  logic [WORD_W-1:0]    rt_val,
    input  logic [REG_IDX_W-1:0] rt_idx,
    input  logic [WORD_W-1:0]    mem_word,
    output logic [WORD_W-1:0]    result,
    output logic                 reg_we,
    output logic [WORD_W-1:0]    wdata,
    output logic                 mem_we,
    output logic                 bad_op
);

    xfer_kind_e        kind;
    logic              is_load;
    logic              is_store;
    logic              is_cond;
    logic              is_bad;
    logic [SH_W-1:0]   sh_fwd;
    logic [SH_W-1:0]   sh_rev;
    logic [SH_W-1:0]   sh_half;
    logic [WORD_W-1:0] ld_val;
    logic [WORD_W-1:0] st_val;

    lsm_decode u_decode (
        .op       (op),
        .kind     (kind),
        .is_load  (is_load),
        .is_store (is_store),
        .is_cond  (is_cond),
        .is_bad   (is_bad)
    );

    lsm_lane_shift #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_shift (
        .lane    (lane),
        .sh_fwd  (sh_fwd),
        .sh_rev  (sh_rev),
        .sh_half (sh_half)
    );

    lsm_load_path #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_load (
        .kind     (kind),
        .lane     (lane),
        .sh_fwd   (sh_fwd),
        .sh_rev   (sh_rev),
        .sh_half  (sh_half),
        .rt_val   (rt_val),
        .mem_word (mem_word),
        .ld_val   (ld_val)
    );

    lsm_store_path #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_store (
        .kind     (kind),
        .sh_fwd   (sh_fwd),
        .sh_rev   (sh_rev),
        .sh_half  (sh_half),
        .rt_val   (rt_val),
        .mem_word (mem_word),
        .st_val   (st_val)
    );

    // Purpose: drive results and enables from the class flags.
    always_comb begin
        bad_op = is_bad;
        mem_we = is_store;
        wdata  = is_store ? st_val : '0;
        reg_we = is_load | (is_cond & (rt_idx != '0));
        if (is_load)      result = ld_val;
        else if (is_cond) result = WORD_W'(1);
        else              result = '0;
    end

    // Purpose: port-level rules for errors, enables and store-conditional.
    always_comb begin
        p_bad_quiet_r11: assert (!bad_op || (!mem_we && !reg_we && result == '0 && wdata == '0))
            else $error("unsupported opcode produced activity");
        p_dual_write_r10: assert (!(mem_we && reg_we) || op == OPC_STCOND)
            else $error("both writes on a non-conditional opcode");
        p_cond_link_r9: assert (op != OPC_STCOND ||
                                (result == WORD_W'(1) && reg_we == (rt_idx != '0) && mem_we))
            else $error("store-conditional link value wrong");
        p_word_pass_r8: assert (op != OPC_STW || wdata == rt_val)
            else $error("word store altered rt");
    end

endmodule

// File: tb/lsm_lane_merge_tb.sv
// Bench for lsm_lane_merge: directed lane sweeps plus seeded random mix,
// compared against a byte-lane reference model written from the requirements.
module lsm_lane_merge_tb;

    logic        clk;
    logic        rst_n;
    logic [5:0]  op;
    logic [1:0]  lane;
    logic [31:0] rt_val;
    logic [4:0]  rt_idx;
    logic [31:0] mem_word;
    logic [31:0] result;
    logic        reg_we;
    logic [31:0] wdata;
    logic        mem_we;
    logic        bad_op;

    int total;
    int bad;
    int cyc;

    lsm_lane_merge u_dut (
        .op       (op),
        .lane     (lane),
        .rt_val   (rt_val),
        .rt_idx   (rt_idx),
        .mem_word (mem_word),
        .result   (result),
        .reg_we   (reg_we),
        .wdata    (wdata),
        .mem_we   (mem_we),
        .bad_op   (bad_op)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic logic [7:0] get_ln(input logic [31:0] w, input int i);
        return w[31 - 8 * i -: 8];
    endfunction

    function automatic logic [31:0] put_ln(input logic [31:0] w, input int i, input logic [7:0] b);
        logic [31:0] r = w;
        r[31 - 8 * i -: 8] = b;
        return r;
    endfunction

    function automatic string req_of(input logic [5:0] o);
        case (o)
            6'h20, 6'h24: return "R1";
            6'h21, 6'h25: return "R2";
            6'h23, 6'h30: return "R3";
            6'h22:        return "R4";
            6'h26:        return "R5";
            6'h28, 6'h29: return "R6";
            6'h2A, 6'h2E: return "R7";
            6'h2B:        return "R8";
            6'h38:        return "R9";
            default:      return "R11";
        endcase
    endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s op=%h lane=%0d actual=%h expected=%h", rq, what, op, lane, act, exp);
        end
    endtask

    // Reference model and comparison for the present inputs.
    task automatic check_now();
        logic [31:0] e_res = 32'h0;
        logic [31:0] e_wd  = 32'h0;
        logic        e_rwe = 1'b0;
        logic        e_mwe = 1'b0;
        logic        e_bad = 1'b0;
        int a = int'(lane);
        int h = a & 2;
        logic [7:0]  b;
        logic [15:0] hw;
        case (op)
            6'h20: begin b = get_ln(mem_word, a); e_res = {{24{b[7]}}, b}; e_rwe = 1; end
            6'h24: begin b = get_ln(mem_word, a); e_res = {24'h0, b}; e_rwe = 1; end
            6'h21: begin hw = {get_ln(mem_word, h), get_ln(mem_word, h + 1)};
                         e_res = {{16{hw[15]}}, hw}; e_rwe = 1; end
            6'h25: begin hw = {get_ln(mem_word, h), get_ln(mem_word, h + 1)};
                         e_res = {16'h0, hw}; e_rwe = 1; end
            6'h23, 6'h30: begin e_res = mem_word; e_rwe = 1; end
            6'h22: begin
                e_res = rt_val;
                for (int i = 0; i < 4; i++)
                    if (i + a <= 3) e_res = put_ln(e_res, i, get_ln(mem_word, i + a));
                e_rwe = 1;
            end
            6'h26: begin
                e_res = rt_val;
                for (int i = 0; i < 4; i++)
                    if (i >= 3 - a) e_res = put_ln(e_res, i, get_ln(mem_word, i - (3 - a)));
                e_rwe = 1;
            end
            6'h28: begin e_wd = put_ln(mem_word, a, rt_val[7:0]); e_mwe = 1; end
            6'h29: begin
                e_wd = put_ln(put_ln(mem_word, h, rt_val[15:8]), h + 1, rt_val[7:0]);
                e_mwe = 1;
            end
            6'h2A: begin
                e_wd = mem_word;
                for (int i = 0; i < 4; i++)
                    if (i >= a) e_wd = put_ln(e_wd, i, get_ln(rt_val, i - a));
                e_mwe = 1;
            end
            6'h2E: begin
                e_wd = mem_word;
                for (int i = 0; i < 4; i++)
                    if (i <= a) e_wd = put_ln(e_wd, i, get_ln(rt_val, i + 3 - a));
                e_mwe = 1;
            end
            6'h2B: begin e_wd = rt_val; e_mwe = 1; end
            6'h38: begin e_wd = rt_val; e_mwe = 1; e_res = 32'd1; e_rwe = (rt_idx != 0); end
            default: e_bad = 1;
        endcase
        chk(req_of(op), "result", result, e_res);
        chk(req_of(op), "wdata", wdata, e_wd);
        chk("R10", "reg_we", {31'h0, reg_we}, {31'h0, e_rwe});
        chk("R10", "mem_we", {31'h0, mem_we}, {31'h0, e_mwe});
        chk("R11", "bad_op", {31'h0, bad_op}, {31'h0, e_bad});
    endtask

    task automatic apply(input logic [5:0] o, input logic [1:0] l, input logic [31:0] r,
                         input logic [4:0] ri, input logic [31:0] m);
        @(posedge clk);
        op = o; lane = l; rt_val = r; rt_idx = ri; mem_word = m;
        @(negedge clk);
        check_now();
    endtask

    // Watchdog: a hung run is a failed check and still summarises.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [5:0] VALID_OPS [14] = '{6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26,
                                              6'h28, 6'h29, 6'h2A, 6'h2B, 6'h2E, 6'h30, 6'h38};

    initial begin
        int seed;
        total = 0; bad = 0; cyc = 0;
        rst_n = 1'b0;
        op = 6'h0; lane = 2'd0; rt_val = 32'h0; rt_idx = 5'd0; mem_word = 32'h0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Idle state: all-zero inputs are an unsupported opcode (R11).
        check_now();

        // R4 R5 R7: unaligned forms at every offset, all bytes distinct.
        for (int l = 0; l < 4; l++) begin
            apply(6'h22, 2'(l), 32'hA1B2C3D4, 5'd3, 32'h11223344);
            apply(6'h26, 2'(l), 32'hA1B2C3D4, 5'd3, 32'h11223344);
            apply(6'h2A, 2'(l), 32'hA1B2C3D4, 5'd3, 32'h11223344);
            apply(6'h2E, 2'(l), 32'hA1B2C3D4, 5'd3, 32'h11223344);
        end
        // R1 R2 R6: sign boundaries on every lane.
        for (int l = 0; l < 4; l++) begin
            apply(6'h20, 2'(l), 32'h0, 5'd7, 32'h80FF7F01);
            apply(6'h24, 2'(l), 32'h0, 5'd7, 32'h80FF7F01);
            apply(6'h21, 2'(l), 32'h0, 5'd7, 32'h80017FFF);
            apply(6'h25, 2'(l), 32'h0, 5'd7, 32'h80017FFF);
            apply(6'h28, 2'(l), 32'hDEADBEEF, 5'd7, 32'h11223344);
            apply(6'h29, 2'(l), 32'hDEADBEEF, 5'd7, 32'h11223344);
        end
        // R3 R8 R9: word forms; store-conditional with rt index zero and nonzero.
        apply(6'h23, 2'd2, 32'h5, 5'd1, 32'hCAFEF00D);
        apply(6'h30, 2'd1, 32'h5, 5'd1, 32'hCAFEF00D);
        apply(6'h2B, 2'd3, 32'h89ABCDEF, 5'd1, 32'h0);
        apply(6'h38, 2'd0, 32'h89ABCDEF, 5'd0, 32'h12345678);
        apply(6'h38, 2'd0, 32'h89ABCDEF, 5'd9, 32'h12345678);
        // R11: neighbours of supported opcodes.
        apply(6'h27, 2'd0, 32'hFFFFFFFF, 5'd4, 32'hFFFFFFFF);
        apply(6'h2C, 2'd1, 32'hFFFFFFFF, 5'd4, 32'hFFFFFFFF);
        apply(6'h31, 2'd2, 32'hFFFFFFFF, 5'd4, 32'hFFFFFFFF);
        apply(6'h1F, 2'd3, 32'hFFFFFFFF, 5'd4, 32'hFFFFFFFF);

        // Seeded random mix over all requirements.
        seed = $urandom(32'h5EED_1234);
        for (int n = 0; n < 3000; n++) begin
            logic [5:0] o;
            logic [4:0] ri;
            if (($urandom % 8) == 0) o = 6'($urandom);
            else                    o = VALID_OPS[$urandom % 14];
            ri = (($urandom % 4) == 0) ? 5'd0 : 5'($urandom);
            apply(o, 2'($urandom), $urandom, ri, $urandom);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule